// File: doc/BRIEF.md
# Colour lookup table loader

The block fetches a palette of up to 256 colours from a byte-addressed memory and then turns 8-bit palette indices into 32-bit ARGB colours. Software places the table in memory, then writes the layer's control fields: a start bit, an entry format (packed 3-byte RGB or 4-byte ARGB), a size field holding the entry count minus one, and the table's base address. The loader then runs by itself. It reads the table one byte at a time, assembles each entry, and expands it to ARGB. When the last entry is stored, it raises a load-complete flag. If the memory answers a read with an error, it raises an access-error flag instead.

The table is held in two banks. A load fills the bank that is not being read. The loader swaps the banks only when the whole table has arrived without error. The pixel path therefore keeps returning the previous palette while a load is running, and also after a load that failed.

The controller has four states:
- ST_IDLE waits for the start bit.
- ST_ISSUE sends one byte read.
- ST_WAIT holds until that read is answered.
- ST_COMMIT writes the assembled entry to the shadow bank.

The transitions are:
- start: ST_IDLE to ST_ISSUE.
- issue: ST_ISSUE to ST_WAIT.
- next_byte: ST_WAIT to ST_ISSUE.
- entry_full: ST_WAIT to ST_COMMIT.
- abort: ST_WAIT to ST_IDLE, taken on a memory error.
- next_entry: ST_COMMIT to ST_ISSUE.
- finish: ST_COMMIT to ST_IDLE, taken after the last entry.

Top module: `clut_loader`

## Requirements
- R1: A start pulse while `load_busy` is 0 is accepted. `load_busy` reads 1 from the next cycle on. The same edge clears `load_done` and `access_err`. The first byte read is at `load_base`.
- R2: `load_size` holds the entry count minus one. A load of size S reads exactly (S+1)×B bytes, at consecutive addresses starting at `load_base`. B is 3 in 24-bit mode (`load_fmt32`=0) and 4 in 32-bit mode (`load_fmt32`=1).
- R3: In 24-bit mode, entry n occupies bytes base+3n, base+3n+1 and base+3n+2, in the order blue, green, red. Its looked-up value is {8'hFF, red, green, blue}.
- R4: In 32-bit mode, entry n is the four bytes at base+4n to base+4n+3, from least to most significant. Its looked-up value is {byte3, byte2, byte1, byte0}, that is alpha, red, green, blue.
- R5: `load_busy` falls on the same edge as `load_done` rises after the last entry is stored. `load_done` then stays 1 until the next accepted start.
- R6: A read answered with `mem_err` ends the load. On that edge `load_busy` falls and `access_err` is set, while `load_done` stays 0. The table visible to lookups stays as it was before the load.
- R7: `pix_argb` shows the entry for the `pix_idx` sampled one clock earlier. While a load is running, lookups return the previous table.
- R8: An index greater than the size of the table in use returns 0. Before the first successful load, every index returns 0.
- R9: A start pulse while `load_busy` is 1 is ignored. The running load keeps its base address, size and format.
- R10: `mem_req` is a single-cycle strobe, asserted only while `load_busy` is 1. At most one read is outstanding; the next request waits for that read's single `mem_rvalid` or `mem_err` response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_start | input | 1 | Start bit of the control register (pulse) |
| load_fmt32 | input | 1 | Entry format: 1 = 4-byte ARGB, 0 = 3-byte RGB |
| load_size | input | 8 | Entry count minus one |
| load_base | input | 16 | Byte address of entry 0 |
| load_busy | output | 1 | Start bit readback: 1 while loading |
| load_done | output | 1 | Load-complete flag |
| access_err | output | 1 | Table access error flag |
| mem_req | output | 1 | Byte read request strobe |
| mem_addr | output | 16 | Byte read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| mem_err | input | 1 | Read answered with an error |
| pix_idx | input | 8 | Palette index |
| pix_argb | output | 32 | Looked-up colour, one cycle later |

## Verification
Most wrong internal state shows up only at the end of a load or in the pixel path. A byte counter or address counter that slips shows as a read count or address sequence that does not match the size and format. It also shows one cycle later as colours with bytes swapped or shifted across entries.

A bank pointer or shadow-size register that updates at the wrong moment shows on `pix_argb`, either while a load is still running or after an aborted one. So lookups are made during loads and after errors, as well as after clean completions.

Random bases, sizes, formats and response latencies are mixed with directed cases: size zero, a full 256-entry table, an index just past the size, and a start pulse while busy.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int ARGB_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_COMMIT
    } fetch_state_e;

    // Expand an assembled entry: 24-bit entries get opaque alpha
    function automatic logic [ARGB_W-1:0] expand_entry(input logic fmt32,
                                                        input logic [ARGB_W-1:0] raw);
        return fmt32 ? raw : {8'hFF, raw[23:0]};
    endfunction
endpackage

// File: rtl/clut_fetch.sv
module clut_fetch
    import clut_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fmt32,
    input  logic [IDX_W-1:0]  size,
    input  logic [ADDR_W-1:0] base,
    output logic              busy,
    output logic              done_flag,
    output logic              err_flag,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ARGB_W-1:0] wr_data,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_size
);
    fetch_state_e state_q, state_n;

    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  size_q;
    logic [IDX_W-1:0]  ent_q;
    logic [1:0]        byte_q;
    logic              fmt_q;
    logic [ARGB_W-1:0] asm_q;
    logic [1:0]        last_byte;
    logic              last_ent;

    assign last_byte = fmt_q ? 2'd3 : 2'd2;
    assign last_ent  = (ent_q == size_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_n = ST_ISSUE;
            ST_ISSUE:  state_n = ST_WAIT;
            ST_WAIT: begin
                if (mem_err)         state_n = ST_IDLE;
                else if (mem_rvalid) state_n = (byte_q == last_byte) ? ST_COMMIT : ST_ISSUE;
            end
            ST_COMMIT: state_n = last_ent ? ST_IDLE : ST_ISSUE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            size_q    <= '0;
            ent_q     <= '0;
            byte_q    <= '0;
            fmt_q     <= 1'b0;
            asm_q     <= '0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                addr_q    <= base;
                size_q    <= size;
                fmt_q     <= fmt32;
                ent_q     <= '0;
                byte_q    <= '0;
                asm_q     <= '0;
                done_flag <= 1'b0;
                err_flag  <= 1'b0;
            end
            if (state_q == ST_WAIT) begin
                if (mem_err) begin
                    err_flag <= 1'b1;
                end else if (mem_rvalid) begin
                    asm_q[{byte_q, 3'b000} +: 8] <= mem_rdata;
                    addr_q <= addr_q + ADDR_W'(1);
                    byte_q <= (byte_q == last_byte) ? 2'd0 : byte_q + 2'd1;
                end
            end
            if (state_q == ST_COMMIT) begin
                if (last_ent) done_flag <= 1'b1;
                else          ent_q     <= ent_q + IDX_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_req     = (state_q == ST_ISSUE);
        mem_addr    = addr_q;
        wr_en       = (state_q == ST_COMMIT);
        wr_idx      = ent_q;
        wr_data     = expand_entry(fmt_q, asm_q);
        commit      = (state_q == ST_COMMIT) && last_ent;
        commit_size = size_q;
    end
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ARGB_W-1:0] wr_data,
    input  logic              commit,
    input  logic [IDX_W-1:0]  commit_size,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ARGB_W-1:0] rd_data
);
    localparam int NBANK = 2;

    logic             act_q;
    logic             valid_q;
    logic [IDX_W-1:0] size_act_q;
    logic [ARGB_W-1:0] bank_rd [NBANK];

    // Shadow bank is written; active bank is read
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic BANK_ID = 1'(b);
        logic [ARGB_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (wr_en && (act_q != BANK_ID)) mem[wr_idx] <= wr_data;
        end

        assign bank_rd[b] = mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            valid_q    <= 1'b0;
            size_act_q <= '0;
            rd_data    <= '0;
        end else begin
            if (commit) begin
                act_q      <= ~act_q;
                valid_q    <= 1'b1;
                size_act_q <= commit_size;
            end
            rd_data <= (!valid_q || rd_idx > size_act_q) ? '0 : bank_rd[act_q];
        end
    end
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              load_fmt32,
    input  logic [IDX_W-1:0]  load_size,
    input  logic [ADDR_W-1:0] load_base,
    output logic              load_busy,
    output logic              load_done,
    output logic              access_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [ARGB_W-1:0] pix_argb
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ARGB_W-1:0] wr_data;
    logic              commit;
    logic [IDX_W-1:0]  commit_size;

    clut_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fetch_i (
        .clk(clk), .rst_n(rst_n),
        .start(load_start), .fmt32(load_fmt32), .size(load_size), .base(load_base),
        .busy(load_busy), .done_flag(load_done), .err_flag(access_err),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .commit(commit), .commit_size(commit_size)
    );

    clut_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .commit(commit), .commit_size(commit_size),
        .rd_idx(pix_idx), .rd_data(pix_argb)
    );
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic load_start,
    input logic load_busy,
    input logic load_done,
    input logic access_err,
    input logic mem_req
);
    // R10
    req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> load_busy);

    // R10
    req_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R1
    start_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_busy) |-> (!load_done && !access_err));

    // R5
    end_sets_one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_busy) |-> (load_done != access_err));

    // R5
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !load_start) |=> load_done);

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && access_err));
endmodule

bind clut_loader clut_loader_chk chk_i (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_busy(load_busy),
    .load_done(load_done), .access_err(access_err), .mem_req(mem_req)
);

// File: tb/clut_loader_tb.sv
`timescale 1ns/1ps
module clut_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_start = 1'b0;
    logic        load_fmt32 = 1'b0;
    logic [7:0]  load_size = '0;
    logic [15:0] load_base = '0;
    logic        load_busy, load_done, access_err, mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic [31:0] pix_argb;

    always #2.5 clk = ~clk;

    clut_loader dut_i (.*);

    // Memory image and responder
    logic [7:0]  mem [4096];
    logic [15:0] err_addr = 16'hFFFF;
    logic        pend = 1'b0;
    int          lat = 0;
    logic [15:0] paddr = '0;
    int          req_cnt = 0;
    int          addr_bad = 0;
    logic [15:0] exp_addr = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_err    <= 1'b0;
        if (mem_req) begin
            pend  <= 1'b1;
            lat   <= int'($urandom_range(0, 2));
            paddr <= mem_addr;
        end else if (pend) begin
            if (lat == 0) begin
                pend <= 1'b0;
                if (paddr == err_addr) mem_err <= 1'b1;
                else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[paddr[11:0]];
                end
            end else lat <= lat - 1;
        end
        if (load_start && !load_busy) begin
            req_cnt  <= 0;
            addr_bad <= 0;
            exp_addr <= load_base;
        end else if (mem_req) begin
            req_cnt  <= req_cnt + 1;
            if (mem_addr != exp_addr) addr_bad <= addr_bad + 1;
            exp_addr <= exp_addr + 16'd1;
        end
    end

    // Reference model
    logic [31:0] exp_tab [256];
    int          exp_sz = 0;
    bit          exp_valid = 0;
    int          compared = 0;
    int          mismatched = 0;
    bit          finished = 0;

    function automatic logic [31:0] ref_entry(input int base, input int n, input bit f32);
        int a;
        a = base + n * (f32 ? 4 : 3);
        if (f32) return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
        return {8'hFF, mem[a+2], mem[a+1], mem[a]};
    endfunction

    function automatic logic [31:0] ref_look(input int idx);
        if (!exp_valid || idx > exp_sz) return 32'h0;
        return exp_tab[idx];
    endfunction

    task automatic model_load(input int base, input int size, input bit f32);
        for (int n = 0; n <= size; n++) exp_tab[n] = ref_entry(base, n, f32);
        exp_sz = size;
        exp_valid = 1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input int idx, input string tag);
        @(negedge clk);
        pix_idx = 8'(idx);
        @(negedge clk);
        chk(tag, pix_argb, ref_look(idx));
    endtask

    task automatic start_load(input int base, input int size, input bit f32);
        @(negedge clk);
        load_base  = 16'(base);
        load_size  = 8'(size);
        load_fmt32 = f32;
        load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (load_busy && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int b, s;
        bit f;
        void'($urandom(32'd4321));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R8: empty table)
        chk("R1 busy at reset", 32'(load_busy), 0);
        chk("R5 done at reset", 32'(load_done), 0);
        chk("R6 err at reset", 32'(access_err), 0);
        look(0, "R8 empty table");

        // Full 32-bit table
        start_load(16'h100, 255, 1);
        chk("R1 busy after start", 32'(load_busy), 1);
        wait_idle();
        chk("R5 done flag", 32'(load_done), 1);
        chk("R6 no error", 32'(access_err), 0);
        chk("R2 byte count 32-bit", req_cnt, 1024);
        chk("R2 address order", addr_bad, 0);
        model_load(16'h100, 255, 1);
        look(0, "R4 first entry");
        look(255, "R4 last entry");
        for (int i = 0; i < 40; i++) look(int'($urandom_range(0, 255)), "R4 random entry");

        // 24-bit load, lookups during load, start while busy
        start_load(16'h505, 15, 0);
        repeat (10) @(negedge clk);
        look(3, "R7 old table during load");
        look(200, "R7 old table during load");
        start_load(16'h900, 3, 1);
        chk("R9 still busy", 32'(load_busy), 1);
        look(77, "R7 old table during load");
        wait_idle();
        chk("R9 byte count of first start", req_cnt, 48);
        chk("R9 address order", addr_bad, 0);
        model_load(16'h505, 15, 0);
        look(15, "R3 last entry alpha");
        look(16, "R8 one past size");
        look(255, "R8 far past size");
        for (int i = 0; i < 20; i++) look(int'($urandom_range(0, 15)), "R3 random entry");

        // Access error mid-load
        err_addr = 16'h200 + 16'd22;
        start_load(16'h200, 63, 1);
        wait_idle();
        chk("R6 err flag", 32'(access_err), 1);
        chk("R6 done stays low", 32'(load_done), 0);
        look(0, "R6 table unchanged");
        look(5, "R6 table unchanged");
        look(30, "R6 table unchanged");
        err_addr = 16'hFFFF;

        // Size zero
        start_load(16'hA00, 0, 0);
        chk("R1 err cleared on start", 32'(access_err), 0);
        wait_idle();
        chk("R5 done size zero", 32'(load_done), 1);
        chk("R2 byte count size zero", req_cnt, 3);
        model_load(16'hA00, 0, 0);
        look(0, "R3 single entry");
        look(1, "R8 past single entry");

        // Random loads
        for (int k = 0; k < 4; k++) begin
            b = int'($urandom_range(0, 16'hBFF));
            s = int'($urandom_range(0, 255));
            f = 1'($urandom);
            start_load(b, s, f);
            wait_idle();
            chk("R5 random load done", 32'(load_done), 1);
            chk("R2 random byte count", req_cnt, (s + 1) * (f ? 4 : 3));
            model_load(b, s, f);
            for (int i = 0; i < 30; i++) look(int'($urandom_range(0, 255)), "R7 random lookup");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule